// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Feedback

This block is a small field-configurable logic array. Four primary inputs and the block's own four outputs drive a programmable AND plane of twelve product terms. A fixed OR plane ties each output to its own three consecutive product terms. Terms cannot be lent from one output to another, so a function that needs more than three terms is split: part of it is built on one output, and that output's value is picked up again as a literal by the terms of another output.

The AND-plane connections and a per-output polarity bit are held in one configuration shift register. That register is loaded serially, one bit per clock while the shift enable is high. The logic path from the inputs to the outputs is purely combinational. It is evaluated as a fixed stack of identical plane copies. Each copy takes the previous copy's outputs as its feedback literals, so an acyclic configuration settles to the value of the multi-level logic it describes. The configuration must not make an output depend on itself, directly or through other outputs.

Top module: `pal_fb_array`

## Requirements
- R1: While reset is asserted, every fuse is set to intact and every polarity bit is cleared. Out of reset, the outputs are therefore 0 for every input value.
- R2: On each rising clock edge with `cfg_en` high, `cfg_bit` enters chain position 0 and every other bit moves up one position. After 196 shifts, the first bit sent sits at position 195. Positions 0 to 3 are the polarity bits of outputs 0 to 3. Position 4+16t+l is the fuse for literal l of term t. Literal 2k is the true form of source k and literal 2k+1 is its complement. Sources 0 to 3 are `in_i[0..3]` and sources 4 to 7 are `out_o[0..3]`. A fuse value of 1 means intact, which means the literal is connected.
- R3: With `cfg_en` low, the chain holds its contents whatever `cfg_bit` does, and the outputs do not move while the inputs are steady.
- R4: A product term is the AND of its intact literals. A term with both forms of any source intact is always 0, and this includes a term whose fuses are all intact.
- R5: Output j is the OR of terms 3j, 3j+1 and 3j+2 only. A term of one output has no effect on any other output except through feedback.
- R6: A set polarity bit complements its output after the OR.
- R7: Outputs are available to every term as true and complement literals. For acyclic configurations, the final outputs equal the multi-level function that is described, with dependency chains up to four outputs long.
- R8: A term with every fuse blown evaluates to 1, which drives its output to 1 before polarity is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| in_i | input | 4 | Primary logic inputs |
| out_o | output | 4 | Logic outputs, also fed back to the AND plane |

## Verification
The assertions take `cfg_en` and `cfg_bit` to be known values at every clock edge. They also assume that the bench holds `cfg_en` low while reset is released. The stimulus changes all inputs only on falling clock edges and never loads a configuration in which an output feeds its own terms, whether directly or through other outputs. The stacked evaluation is checked only against functions whose dependency depth fits within the four plane copies.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned PAL_N_IN    = 4;
    localparam int unsigned PAL_N_OUT   = 4;
    localparam int unsigned PAL_T_PER_O = 3;

    // literals per term: true and complement of every input and every output
    function automatic int unsigned pal_lits(input int unsigned n_in, input int unsigned n_out);
        return 2 * (n_in + n_out);
    endfunction

    // polarity bits at the bottom of the chain, fuses above them
    function automatic int unsigned pal_cfg_width(input int unsigned n_in, input int unsigned n_out,
                                                  input int unsigned tpo);
        return n_out + n_out * tpo * pal_lits(n_in, n_out);
    endfunction
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int unsigned W      = 16,
    parameter int unsigned N_POL  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en_i,
    input  logic         bit_i,
    output logic [W-1:0] cfg_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } chain_t;

    localparam logic [W-1:0] RST_VAL = {{(W-N_POL){1'b1}}, {N_POL{1'b0}}};

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i) begin
            st_d.bits = {st_q.bits[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.bits;
endmodule

// File: rtl/pal_plane.sv
module pal_plane #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_OUT = 4,
    parameter int unsigned TPO   = 3
) (
    input  logic [N_IN-1:0]                              in_i,
    input  logic [N_OUT-1:0]                             fb_i,
    input  logic [N_OUT*TPO*pal_pkg::pal_lits(N_IN,N_OUT)-1:0] fuse_i,
    input  logic [N_OUT-1:0]                             pol_i,
    output logic [N_OUT-1:0]                             out_o
);
    localparam int unsigned N_SRC = N_IN + N_OUT;
    localparam int unsigned LITS  = pal_pkg::pal_lits(N_IN, N_OUT);
    localparam int unsigned TERMS = N_OUT * TPO;

    logic [N_SRC-1:0] src;
    logic [LITS-1:0]  lits;
    logic [TERMS-1:0] term;

    assign src = {fb_i, in_i};

    for (genvar k = 0; k < N_SRC; k++) begin : g_lit
        assign lits[2*k]   = src[k];
        assign lits[2*k+1] = ~src[k];
    end

    // a blown fuse forces its literal position to 1 in the AND
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign term[t] = &(lits | ~fuse_i[t*LITS +: LITS]);
    end

    // fixed OR plane: each output owns a consecutive group of terms
    for (genvar j = 0; j < N_OUT; j++) begin : g_or
        assign out_o[j] = (|term[j*TPO +: TPO]) ^ pol_i[j];
    end
endmodule

// File: rtl/pal_fb_array.sv
module pal_fb_array #(
    parameter int unsigned N_IN  = pal_pkg::PAL_N_IN,
    parameter int unsigned N_OUT = pal_pkg::PAL_N_OUT,
    parameter int unsigned TPO   = pal_pkg::PAL_T_PER_O
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_i,
    output logic [N_OUT-1:0] out_o
);
    localparam int unsigned LITS   = pal_pkg::pal_lits(N_IN, N_OUT);
    localparam int unsigned FUSE_W = N_OUT * TPO * LITS;
    localparam int unsigned CFG_W  = pal_pkg::pal_cfg_width(N_IN, N_OUT, TPO);
    // longest acyclic dependency chain spans every output once
    localparam int unsigned LEVELS = N_OUT;

    logic [CFG_W-1:0] cfg_q;

    pal_cfg_chain #(.W(CFG_W), .N_POL(N_OUT)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (cfg_en),
        .bit_i      (cfg_bit),
        .cfg_o      (cfg_q)
    );

    for (genvar v = 0; v < LEVELS; v++) begin : g_lvl
        logic [N_OUT-1:0] fb;
        logic [N_OUT-1:0] q;
        if (v == 0) begin : g_first
            assign fb = '0;
        end else begin : g_next
            assign fb = g_lvl[v-1].q;
        end
        pal_plane #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_plane (
            .in_i   (in_i),
            .fb_i   (fb),
            .fuse_i (cfg_q[N_OUT +: FUSE_W]),
            .pol_i  (cfg_q[N_OUT-1:0]),
            .out_o  (q)
        );
    end

    assign out_o = g_lvl[LEVELS-1].q;
endmodule

// File: rtl/pal_fb_chk.sv
module pal_fb_chk #(
    parameter int unsigned CFG_W = 16,
    parameter int unsigned N_OUT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_bit,
    input logic [CFG_W-1:0] cfg_q,
    input logic [N_OUT-1:0] out_o
);
    // R1
    rst_out_zero_chk: assert property (@(posedge clk) !rst_n |=> out_o == '0)
        else $error("outputs not cleared by reset");

    // R2
    shift_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_q[0] == $past(cfg_bit))
        else $error("serial bit not captured at position 0");

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]))
        else $error("chain did not move up by one");

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q))
        else $error("chain changed with shift disabled");
endmodule

bind pal_fb_array pal_fb_chk #(.CFG_W(CFG_W), .N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q),
    .out_o   (out_o)
);

// File: tb/pal_fb_array_tb.sv
`timescale 1ns/1ps
module pal_fb_array_tb_top;
    localparam int CW = 196;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [3:0] in_i = 4'h0;
    logic [3:0] out_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pal_fb_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .in_i(in_i), .out_o(out_o)
    );

    // pass-through config with output 1 inverted: {input, expected}
    localparam logic [7:0] PASS_VEC [6] = '{
        8'h02, 8'h13, 8'h57, 8'hA8, 8'hFD, 8'h64
    };

    function automatic logic [15:0] tl(input int k); return 16'(1) << (2*k);   endfunction
    function automatic logic [15:0] cl(input int k); return 16'(1) << (2*k+1); endfunction

    function automatic logic [CW-1:0] blank();
        return {{(CW-4){1'b1}}, 4'b0000};
    endfunction

    function automatic logic [CW-1:0] put(input logic [CW-1:0] img, input int t, input logic [15:0] l);
        logic [CW-1:0] r = img;
        r[4 + 16*t +: 16] = l;
        return r;
    endfunction

    function automatic logic [3:0] ref_fact(input logic [3:0] v);
        logic a, b, c, d, w, f1, o2, o3;
        a = v[0]; b = v[1]; c = v[2]; d = v[3];
        w  = (a & b) | (c & d);
        f1 = (w & ~a) | (b & c & ~d);
        o2 = ~w | (a & d);
        o3 = ~((o2 & c) | (~a & ~b));
        return {o3, o2, f1, w};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [CW-1:0] img);
        for (int i = CW-1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = img[i];
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic apply(input logic [3:0] v);
        @(negedge clk);
        in_i = v;
        #1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 4'h0, 4'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] img;
        logic [3:0]    held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset configuration yields zero outputs
        for (int v = 0; v < 16; v += 5) begin
            apply(4'(v));
            check("R1", out_o, 4'h0);
        end

        // R2 R5 R6: out j = in j through term 3j, output 1 inverted
        img = blank();
        for (int j = 0; j < 4; j++) img = put(img, 3*j, tl(j));
        img[1] = 1'b1;
        load(img);
        for (int n = 0; n < 6; n++) begin
            apply(PASS_VEC[n][7:4]);
            check("R2 R5 R6", out_o, PASS_VEC[n][3:0]);
        end

        // R7: factored multi-level function via feedback
        img = blank();
        img = put(img, 0, tl(0) | tl(1));
        img = put(img, 1, tl(2) | tl(3));
        img = put(img, 3, tl(4) | cl(0));
        img = put(img, 4, tl(1) | tl(2) | cl(3));
        img = put(img, 6, cl(4));
        img = put(img, 7, tl(0) | tl(3));
        img = put(img, 9, tl(6) | tl(2));
        img = put(img, 10, cl(0) | cl(1));
        img[3] = 1'b1;
        load(img);
        for (int v = 0; v < 16; v++) begin
            apply(4'(v));
            check("R7", out_o, ref_fact(4'(v)));
        end

        // R3: shift disabled, cfg_bit toggling, outputs hold
        apply(4'h9);
        held = out_o;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            cfg_bit = n[0];
        end
        #1;
        check("R3", out_o, held);
        check("R3", out_o, ref_fact(4'h9));

        // R4: conflicting literals give 0; plain AND term on output 1
        img = blank();
        img = put(img, 0, tl(0) | cl(0));
        img = put(img, 3, tl(0) | tl(1));
        load(img);
        apply(4'hF);
        check("R4", out_o, 4'h2);
        apply(4'h1);
        check("R4", out_o, 4'h0);

        // R8: term with every fuse blown drives output 2 high
        img = blank();
        img = put(img, 7, 16'h0000);
        load(img);
        apply(4'h0);
        check("R8", out_o, 4'h4);
        apply(4'hB);
        check("R8", out_o, 4'h4);

        // R1: reset during operation restores the cleared configuration
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", out_o, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'h7);
        check("R1", out_o, 4'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule